// File: doc/BRIEF.md
# Descriptor Selector Check and Privilege Adjust Engine

This block runs the five selector-test operations of a segmented processor: a readability check, a writability check, an access-rights load, a segment-limit load and a requested-privilege adjust. A start pulse hands it an operation code, a 16-bit selector, the privilege field of a second selector, and a protected-mode flag. It also sees the base and limit of the global and local descriptor tables.

For the four table operations the engine picks the table from selector bit 2, forms the descriptor offset, and checks it against that table's limit. It then fetches descriptor bytes through a byte-wide read port with a ready handshake. The privilege adjust needs no memory. When the operation ends, the engine pulses `done_o`. In that same cycle it offers a 16-bit result with a write strobe, an updated zero flag, or an illegal-operation flag. It accepts a new operation only while idle.

Top module: `selchk_unit`

## Requirements
- R1: Selector bit 2 chooses the local table when 1 and the global table when 0. The descriptor offset is the selector with bits 2..0 cleared. A byte at descriptor offset k is read at address table_base + offset + k.
- R2: A selector is in range only when its offset is strictly less than the chosen table's limit. An out-of-range selector on any table operation gives zf_o=0, no result write and no memory read.
- R3: Operation code 0 (read check) fetches the access byte at offset 5. It sets zf_o=1 exactly when the selector is in range and (bit 3 of the byte is 0 or bit 1 is 1), otherwise zf_o=0. It never writes a result.
- R4: Operation code 1 (write check) fetches the access byte at offset 5. It sets zf_o=1 exactly when the selector is in range, bit 3 is 0 and bit 1 is 1, otherwise zf_o=0. It never writes a result.
- R5: Operation code 2 (rights load), when in range, writes the access byte at offset 5 shifted left by 8 with res_we_o=1 and sets zf_o=1.
- R6: Operation code 3 (limit load), when in range, performs two byte reads: offset 0 first, then offset 1. It writes {byte1, byte0} with res_we_o=1 and sets zf_o=1.
- R7: Operation code 4 (privilege adjust) reads no memory. When bits 1..0 of sel_i are less than src_rpl_i, it writes {sel_i[15:2], src_rpl_i} and sets zf_o=1. Otherwise it sets zf_o=0 with no write.
- R8: With prot_en_i=0, operation codes 0, 1, 3 and 4 raise ill_o. Codes 5 to 7 raise ill_o in any mode. An illegal operation reads no memory, writes no result and leaves zf_o unchanged.
- R9: Operation code 2 runs normally with prot_en_i=0.
- R10: mem_rd_o stays high with mem_addr_o stable until mem_rdy_i is seen. The byte on mem_data_i is taken in the cycle mem_rdy_i is high. mem_rd_o is never high while idle.
- R11: done_o is a one-cycle pulse per accepted operation. res_we_o and ill_o are high only with done_o. start_i while busy_o=1 is ignored.
- R12: After reset the engine is idle, with done_o=0, zf_o=0, res_o=0 and mem_rd_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start an operation (taken when idle) |
| op_i | input | 3 | Operation code 0..4, 5..7 illegal |
| sel_i | input | 16 | Selector operand (destination for adjust) |
| src_rpl_i | input | 2 | Privilege field of the source selector |
| prot_en_i | input | 1 | Protected mode enabled |
| glob_base_i | input | ADDR_W | Global table base address |
| glob_lim_i | input | 16 | Global table limit |
| loc_base_i | input | ADDR_W | Local table base address |
| loc_lim_i | input | 16 | Local table limit |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | ADDR_W | Byte read address |
| mem_data_i | input | 8 | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Read completes this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| res_o | output | 16 | Result value |
| res_we_o | output | 1 | Result write strobe |
| zf_o | output | 1 | Zero flag |
| ill_o | output | 1 | Illegal-operation flag |

## Verification
Three operations are each swept over 64 descriptor indices in both tables: read check, write check and rights load. The table limits are set so that the last in-range index and the first out-of-range index are both hit, and the access bytes are drawn from an address hash, which separates the read test from the write test bit by bit. The limit load uses the same sweep and adds checks on read order and address. The privilege adjust is run over all 16 pairs of destination and source privilege values. Every operation code is tried with protected mode off, and codes 5 to 7 also with it on, which tells the illegal path apart from the real-mode rights load. A start pulse is also given during a slow limit load to show it is dropped.

// File: rtl/selchk_pkg.sv
// Shared types and constants for the selector check engine.
// Assumes 16-bit selectors and a byte-wide descriptor read port.
package selchk_pkg;
    localparam int SEL_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int RPL_W   = 2;
    localparam int TI_BIT  = 2;
    localparam int IDX_LSB = 3;
    localparam int ACC_OFF = 5;
    localparam int ACC_CODE_BIT = 3;
    localparam int ACC_RW_BIT   = 1;

    typedef enum logic [2:0] {
        OP_RDCHK  = 3'd0,
        OP_WRCHK  = 3'd1,
        OP_RIGHTS = 3'd2,
        OP_LIMIT  = 3'd3,
        OP_RPLADJ = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACC, ST_LO, ST_HI, ST_DONE
    } st_e;
endpackage

// File: rtl/selchk_locate.sv
// Descriptor locator: picks the table from the indicator bit, forms the
// byte address and the range check. Purely combinational.
module selchk_locate
    import selchk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [SEL_W-1:IDX_LSB] idx_i,
    input  logic                   ti_i,
    input  logic [2:0]             byte_off_i,
    input  logic [ADDR_W-1:0]      glob_base_i,
    input  logic [SEL_W-1:0]       glob_lim_i,
    input  logic [ADDR_W-1:0]      loc_base_i,
    input  logic [SEL_W-1:0]       loc_lim_i,
    output logic [ADDR_W-1:0]      addr_o,
    output logic                   in_range_o
);
    logic [SEL_W-1:0]  offset;
    logic [SEL_W-1:0]  lim;
    logic [ADDR_W-1:0] base;

    // Table selection, range compare and address sum.
    always_comb begin
        offset     = {idx_i, {IDX_LSB{1'b0}}};
        lim        = ti_i ? loc_lim_i  : glob_lim_i;
        base       = ti_i ? loc_base_i : glob_base_i;
        in_range_o = offset < lim;
        addr_o     = base + ADDR_W'(offset) + ADDR_W'(byte_off_i);
    end
endmodule

// File: rtl/selchk_rights.sv
// Access byte tests: readable and writeable segment checks.
module selchk_rights
    import selchk_pkg::*;
(
    input  logic [BYTE_W-1:0] acc_i,
    output logic              rd_ok_o,
    output logic              wr_ok_o
);
    logic code_seg;
    logic rw_bit;
    logic unused_bits;

    // Data segments are readable; code segments need the read-enable bit.
    always_comb begin
        code_seg    = acc_i[ACC_CODE_BIT];
        rw_bit      = acc_i[ACC_RW_BIT];
        rd_ok_o     = !code_seg || rw_bit;
        wr_ok_o     = !code_seg && rw_bit;
        unused_bits = ^{acc_i[BYTE_W-1:ACC_CODE_BIT+1], acc_i[ACC_CODE_BIT-1:ACC_RW_BIT+1], acc_i[0]};
    end
endmodule

// File: rtl/selchk_rpladj.sv
// Privilege adjust: raises the destination privilege field to the source.
module selchk_rpladj
    import selchk_pkg::*;
(
    input  logic [SEL_W-1:0] dst_i,
    input  logic [RPL_W-1:0] src_rpl_i,
    output logic             adj_ok_o,
    output logic [SEL_W-1:0] adj_val_o
);
    // Compare the privilege fields and splice in the source field.
    always_comb begin
        adj_ok_o  = dst_i[RPL_W-1:0] < src_rpl_i;
        adj_val_o = {dst_i[SEL_W-1:RPL_W], src_rpl_i};
    end
endmodule

// File: rtl/selchk_unit.sv
// Selector check engine top. Accepts one operation while idle, fetches
// descriptor bytes through a ready-handshake port, and reports with a
// one-cycle done pulse. Assumes table bases and limits are stable while busy.
module selchk_unit
    import selchk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2:0]           op_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [RPL_W-1:0]     src_rpl_i,
    input  logic                 prot_en_i,
    input  logic [ADDR_W-1:0]    glob_base_i,
    input  logic [SEL_W-1:0]     glob_lim_i,
    input  logic [ADDR_W-1:0]    loc_base_i,
    input  logic [SEL_W-1:0]     loc_lim_i,
    output logic                 mem_rd_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic [BYTE_W-1:0]    mem_data_i,
    input  logic                 mem_rdy_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [SEL_W-1:0]     res_o,
    output logic                 res_we_o,
    output logic                 zf_o,
    output logic                 ill_o
);
    st_e                   state;
    op_e                   op_q;
    logic [SEL_W-1:IDX_LSB] idx_q;
    logic                  ti_q;
    logic [BYTE_W-1:0]     lo_q;
    logic [SEL_W-1:0]      res_q;
    logic                  zf_q;
    logic                  we_q;
    logic                  ill_q;

    logic [SEL_W-1:IDX_LSB] loc_idx;
    logic                  loc_ti;
    logic [2:0]            byte_off;
    logic                  in_range;
    logic                  rd_ok;
    logic                  wr_ok;
    logic                  adj_ok;
    logic [SEL_W-1:0]      adj_val;
    logic                  illegal;

    // Locator input: live selector while idle, latched one while busy.
    always_comb begin
        loc_idx  = (state == ST_IDLE) ? sel_i[SEL_W-1:IDX_LSB] : idx_q;
        loc_ti   = (state == ST_IDLE) ? sel_i[TI_BIT] : ti_q;
        case (state)
            ST_ACC:  byte_off = 3'(ACC_OFF);
            ST_HI:   byte_off = 3'd1;
            default: byte_off = 3'd0;
        endcase
        illegal = (op_i > 3'(OP_RPLADJ)) || (!prot_en_i && op_i != 3'(OP_RIGHTS));
    end

    selchk_locate #(.ADDR_W(ADDR_W)) u_locate (
        .idx_i       (loc_idx),
        .ti_i        (loc_ti),
        .byte_off_i  (byte_off),
        .glob_base_i (glob_base_i),
        .glob_lim_i  (glob_lim_i),
        .loc_base_i  (loc_base_i),
        .loc_lim_i   (loc_lim_i),
        .addr_o      (mem_addr_o),
        .in_range_o  (in_range)
    );

    selchk_rights u_rights (
        .acc_i   (mem_data_i),
        .rd_ok_o (rd_ok),
        .wr_ok_o (wr_ok)
    );

    selchk_rpladj u_rpladj (
        .dst_i     (sel_i),
        .src_rpl_i (src_rpl_i),
        .adj_ok_o  (adj_ok),
        .adj_val_o (adj_val)
    );

    // Operation sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_RDCHK;
            idx_q <= '0;
            ti_q  <= 1'b0;
            lo_q  <= '0;
            res_q <= '0;
            zf_q  <= 1'b0;
            we_q  <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q  <= op_e'(op_i);
                        idx_q <= sel_i[SEL_W-1:IDX_LSB];
                        ti_q  <= sel_i[TI_BIT];
                        we_q  <= 1'b0;
                        ill_q <= 1'b0;
                        if (illegal) begin
                            ill_q <= 1'b1;
                            state <= ST_DONE;
                        end else if (op_i == 3'(OP_RPLADJ)) begin
                            zf_q  <= adj_ok;
                            we_q  <= adj_ok;
                            if (adj_ok) res_q <= adj_val;
                            state <= ST_DONE;
                        end else if (!in_range) begin
                            zf_q  <= 1'b0;
                            state <= ST_DONE;
                        end else if (op_i == 3'(OP_LIMIT)) begin
                            state <= ST_LO;
                        end else begin
                            state <= ST_ACC;
                        end
                    end
                end
                ST_ACC: begin
                    if (mem_rdy_i) begin
                        case (op_q)
                            OP_RDCHK: zf_q <= rd_ok;
                            OP_WRCHK: zf_q <= wr_ok;
                            default: begin
                                zf_q  <= 1'b1;
                                we_q  <= 1'b1;
                                res_q <= {mem_data_i, {BYTE_W{1'b0}}};
                            end
                        endcase
                        state <= ST_DONE;
                    end
                end
                ST_LO: begin
                    if (mem_rdy_i) begin
                        lo_q  <= mem_data_i;
                        state <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (mem_rdy_i) begin
                        res_q <= {mem_data_i, lo_q};
                        zf_q  <= 1'b1;
                        we_q  <= 1'b1;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and result registers.
    always_comb begin
        busy_o   = state != ST_IDLE;
        done_o   = state == ST_DONE;
        mem_rd_o = (state == ST_ACC) || (state == ST_LO) || (state == ST_HI);
        res_o    = res_q;
        zf_o     = zf_q;
        res_we_o = done_o && we_q;
        ill_o    = done_o && ill_q;
    end
endmodule

// File: rtl/selchk_unit_chk.sv
// Property checker for selchk_unit, attached with bind below.
module selchk_unit_chk
    import selchk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic [SEL_W-1:0]  sel_i,
    input logic [RPL_W-1:0]  src_rpl_i,
    input logic              prot_en_i,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rdy_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [SEL_W-1:0]  res_o,
    input logic              res_we_o,
    input logic              zf_o,
    input logic              ill_o
);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_we_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |-> done_o);

    p_ill_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> (done_o && !res_we_o));

    p_realmode_ill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !prot_en_i && op_i != 3'd2) |=> (done_o && ill_o));

    p_rpl_adjust_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && prot_en_i && op_i == 3'd4 && sel_i[1:0] < src_rpl_i)
        |=> (done_o && res_we_o && zf_o && res_o == {$past(sel_i[SEL_W-1:RPL_W]), $past(src_rpl_i)}));

    p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_rd_o);
endmodule

bind selchk_unit selchk_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .sel_i      (sel_i),
    .src_rpl_i  (src_rpl_i),
    .prot_en_i  (prot_en_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdy_i  (mem_rdy_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .res_o      (res_o),
    .res_we_o   (res_we_o),
    .zf_o       (zf_o),
    .ill_o      (ill_o)
);

// File: tb/selchk_unit_tb_top.sv
`timescale 1ns/1ps
module selchk_unit_tb_top;
    localparam int AW = 24;
    localparam logic [AW-1:0] GB = 24'h001000;
    localparam logic [15:0]   GL = 16'h0180;
    localparam logic [AW-1:0] LB = 24'h020400;
    localparam logic [15:0]   LL = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [15:0] sel_i = '0;
    logic [1:0] src_rpl_i = '0;
    logic prot_en_i = 1'b0;
    logic mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_data_i = '0;
    logic mem_rdy_i = 1'b0;
    logic busy_o, done_o, res_we_o, zf_o, ill_o;
    logic [15:0] res_o;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    logic [AW-1:0] addr_prev = '0, addr_last = '0;
    logic [15:0] c_res;
    logic c_we, c_zf, c_ill, c_done;
    int c_rds;

    always #2.5 clk = ~clk;

    selchk_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sel_i(sel_i),
        .src_rpl_i(src_rpl_i), .prot_en_i(prot_en_i),
        .glob_base_i(GB), .glob_lim_i(GL), .loc_base_i(LB), .loc_lim_i(LL),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .mem_rdy_i(mem_rdy_i), .busy_o(busy_o), .done_o(done_o), .res_o(res_o),
        .res_we_o(res_we_o), .zf_o(zf_o), .ill_o(ill_o)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd29 + a[15:8] + a[23:16] + 8'd5);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: variable wait states, data valid with ready.
    initial begin
        int wcnt = 0;
        int pat = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_rdy_i = 1'b0;
                wcnt = 0;
            end else if (mem_rdy_i) begin
                mem_rdy_i = 1'b0;
                wcnt = pat;
                pat = (pat + 1) % 3;
            end else if (mem_rd_o) begin
                if (wcnt == 0) begin
                    mem_rdy_i = 1'b1;
                    mem_data_i = mem_byte(mem_addr_o);
                    addr_prev = addr_last;
                    addr_last = mem_addr_o;
                    rd_cnt++;
                end else begin
                    wcnt--;
                end
            end
        end
    end

    task automatic run(input logic [2:0] op, input logic [15:0] sel, input logic [1:0] srpl, input logic prot);
        int n = 0;
        int r0;
        @(negedge clk);
        r0 = rd_cnt;
        op_i = op; sel_i = sel; src_rpl_i = srpl; prot_en_i = prot; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        c_done = done_o; c_res = res_o; c_we = res_we_o; c_zf = zf_o; c_ill = ill_o;
        c_rds = rd_cnt - r0;
        chk(c_done, "R11 done timeout", 32'(n), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lim, off, sel, exp_res;
        logic [AW-1:0] base, a;
        logic [7:0] acc;
        logic inr, ezf, zf_before;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !zf_o && res_o == 16'h0 && !busy_o && !mem_rd_o, "R12 reset state",
            {res_o, 11'd0, done_o, zf_o, busy_o, mem_rd_o, 1'b0}, 32'd0);

        // Read check, write check, rights load over both tables.
        for (int op = 0; op < 3; op++) begin
            for (int ti = 0; ti < 2; ti++) begin
                for (int idx = 0; idx < 64; idx++) begin
                    sel  = {idx[12:0], ti[0], idx[1:0]};
                    off  = {idx[12:0], 3'b000};
                    lim  = ti ? LL : GL;
                    base = ti ? LB : GB;
                    inr  = off < lim;
                    a    = base + AW'(off) + 24'd5;
                    acc  = mem_byte(a);
                    run(op[2:0], sel, 2'd0, 1'b1);
                    case (op)
                        0: ezf = inr && (!acc[3] || acc[1]);
                        1: ezf = inr && !acc[3] && acc[1];
                        default: ezf = inr;
                    endcase
                    if (op == 0) chk(c_zf == ezf, "R3 read check zf", 32'(c_zf), 32'(ezf));
                    if (op == 1) chk(c_zf == ezf, "R4 write check zf", 32'(c_zf), 32'(ezf));
                    if (op == 2) chk(c_zf == ezf, "R5 rights zf", 32'(c_zf), 32'(ezf));
                    chk(c_we == (op == 2 && inr), "R5 write strobe", 32'(c_we), 32'(op == 2 && inr));
                    chk(c_rds == (inr ? 1 : 0), "R2 read count", 32'(c_rds), 32'(inr ? 1 : 0));
                    if (inr) chk(addr_last == a, "R1 access byte address", 32'(addr_last), 32'(a));
                    if (op == 2 && inr) chk(c_res == {acc, 8'h00}, "R5 rights value", 32'(c_res), 32'({acc, 8'h00}));
                    chk(!c_ill, "R8 no ill in prot mode", 32'(c_ill), 32'd0);
                end
            end
        end

        // Explicit limit boundary in the global table.
        run(3'd0, {13'h2F, 3'b000}, 2'd0, 1'b1);
        chk(c_rds == 1, "R2 last in-range index", 32'(c_rds), 32'd1);
        run(3'd0, {13'h30, 3'b000}, 2'd0, 1'b1);
        chk(c_rds == 0 && !c_zf, "R2 offset equal to limit", 32'({c_rds[7:0], 7'd0, c_zf}), 32'd0);

        // Limit load sweep.
        for (int ti = 0; ti < 2; ti++) begin
            for (int idx = 0; idx < 64; idx++) begin
                sel  = {idx[12:0], ti[0], 2'b11};
                off  = {idx[12:0], 3'b000};
                lim  = ti ? LL : GL;
                base = ti ? LB : GB;
                inr  = off < lim;
                a    = base + AW'(off);
                run(3'd3, sel, 2'd0, 1'b1);
                chk(c_zf == inr && c_we == inr, "R6 limit flags", 32'({c_zf, c_we}), 32'({inr, inr}));
                chk(c_rds == (inr ? 2 : 0), "R6 limit read count", 32'(c_rds), 32'(inr ? 2 : 0));
                if (inr) begin
                    exp_res = {mem_byte(a + 24'd1), mem_byte(a)};
                    chk(c_res == exp_res, "R6 limit value", 32'(c_res), 32'(exp_res));
                    chk(addr_prev == a && addr_last == a + 24'd1, "R6 low byte first",
                        32'(addr_prev), 32'(a));
                end
            end
        end

        // Privilege adjust over all field pairs.
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 4; s++) begin
                sel = 16'(16'h1234 * (d * 4 + s + 1));
                sel[1:0] = d[1:0];
                run(3'd4, sel, s[1:0], 1'b1);
                chk(c_zf == (d < s) && c_we == (d < s), "R7 adjust flags",
                    32'({c_zf, c_we}), 32'({d < s, d < s}));
                chk(c_rds == 0, "R7 no memory", 32'(c_rds), 32'd0);
                if (d < s) chk(c_res == {sel[15:2], s[1:0]}, "R7 adjust value",
                    32'(c_res), 32'({sel[15:2], s[1:0]}));
            end
        end

        // Illegal codes and real mode.
        for (int p = 0; p < 2; p++) begin
            for (int op = 0; op < 8; op++) begin
                if (p == 1 && op < 5) continue;
                run(3'd4, 16'h0000, op[0] ? 2'd1 : 2'd0, 1'b1);
                zf_before = op[0];
                chk(c_zf == zf_before, "R7 preset zf", 32'(c_zf), 32'(zf_before));
                run(op[2:0], 16'h0008, 2'd3, p[0]);
                if (op == 2) begin
                    a = GB + 24'd8 + 24'd5;
                    chk(!c_ill && c_zf && c_we && c_res == {mem_byte(a), 8'h00}, "R9 rights in real mode",
                        32'(c_res), 32'({mem_byte(a), 8'h00}));
                end else begin
                    chk(c_ill, "R8 illegal raised", 32'(c_ill), 32'd1);
                    chk(!c_we && c_rds == 0, "R8 no write no read", 32'({c_we, c_rds[7:0]}), 32'd0);
                    chk(c_zf == zf_before, "R8 zf unchanged", 32'(c_zf), 32'(zf_before));
                end
            end
        end

        // Start while busy is ignored.
        begin
            int dones = 0;
            a = LB + 24'd16;
            @(negedge clk);
            op_i = 3'd3; sel_i = 16'h0014; prot_en_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            op_i = 3'd4; sel_i = 16'h0000; src_rpl_i = 2'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (done_o) begin
                    dones++;
                    c_res = res_o;
                end
                @(negedge clk);
            end
            chk(dones == 1, "R11 one done per accepted start", 32'(dones), 32'd1);
            exp_res = {mem_byte(a + 24'd1), mem_byte(a)};
            chk(c_res == exp_res, "R11 busy start ignored", 32'(c_res), 32'(exp_res));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule